// File: doc/BRIEF.md
# Peripheral Clock Gate Bank with Set/Clear Registers

This block holds the on/off request for a set of peripheral clocks and drives one gate-enable output per clock. The clocks are split into groups of 32. Each group has its own window of four word registers on a simple 32-bit register bus. Writing ones to the group's set register turns clocks on. Writing ones to the group's clear register turns them off. Every zero bit in such a write leaves its clock alone, so no read-modify-write is needed and two agents can never undo each other's change.

Each group also has a request register, which reports what software asked for, and a status register, which reports what the gates actually do. Status trails request by a fixed two-cycle synchronisation pipeline, so software writes a set or clear and then polls status until the bit settles. The reset value of the request is a parameter, so boot-critical clocks such as a memory controller's come out of reset already running. Clock number n lives in group n/32 at bit n%32. Each gate output is the status bit qualified by a shared clock-enable input.

Top module: `clkgate_bank`

## Requirements
- R1: A write to a group's set register (group 0 at byte offset 0x24, group 1 at 0x34) sets every request bit written as 1 and leaves every bit written as 0 unchanged.
- R2: A write to a group's clear register (group 0 at 0x28, group 1 at 0x38) clears every request bit written as 1 and leaves every bit written as 0 unchanged.
- R3: Clock n is controlled by bit n%32 of group n/32, and gate_o[n] is its output. A write to one group's registers never changes another group's request.
- R4: A read of a group's request register (group 0 at 0x2C, group 1 at 0x3C) returns the current request word, including a change made by the write one cycle earlier.
- R5: The status register (group 0 at 0x30, group 1 at 0x40) equals the request exactly two clock cycles earlier. After a write at edge E, the new value is visible after edge E+2 and not before.
- R6: While the synchronous reset rst_i is high, and immediately after it falls, both request and status equal the parameter RST_REQ. Group g takes bits [32g+31:32g].
- R7: Reads of the set and clear registers return 0.
- R8: Reads of any offset that is not one of the eight registers, a misaligned one included, return 0. A write to such an offset, or to a request or status register, changes nothing.
- R9: gate_o equals the status of all groups, with group 1 in the upper 32 bits, when clk_en_i is 1, and is all zeros when clk_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| clk_en_i | input | 1 | Shared qualifier applied to every gate output |
| gate_o | output | 64 | Per-clock gate enable, bit n for clock n |

## Verification
The set and clear paths are driven with sparse masks, all-ones masks and an all-zero mask. This separates writing only the ones from overwriting the whole word, and it shows whether a zero bit is truly left alone. The same patterns are sent to group 1, where bits at both ends of the word show whether the bit-to-clock mapping and the isolation between groups hold. Writes to request, status and unmapped offsets must leave both request words unchanged. A step-by-step poll after a single write counts the exact two-cycle lag of status and of the gate outputs.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Width of one group: one bus word.
    localparam int GRP_W      = 32;
    // Register window of group 0 and distance between group windows.
    localparam int GRP_BASE   = 'h24;
    localparam int GRP_STRIDE = 'h10;
    // Number of registers in one group window, 4 bytes apart.
    localparam int REGS_PER_GRP = 4;
    // Fixed request-to-status synchronisation latency in cycles.
    localparam int SYNC_LAT   = 2;

    typedef enum logic [1:0] {
        RK_SET  = 2'd0,
        RK_CLR  = 2'd1,
        RK_REQ  = 2'd2,
        RK_STAT = 2'd3
    } reg_kind_e;

    typedef logic [GRP_W-1:0] grp_word_t;

    // Registered state of one group.
    typedef struct packed {
        grp_word_t req;
        grp_word_t mid;
        grp_word_t stat;
        logic [1:0] age;
    } grp_state_t;

endpackage

// File: rtl/cg_decode.sv
module cg_decode
    import clkgate_pkg::*;
#(
    parameter int NUM_GRP = 2,
    parameter int ADDR_W  = 8
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_GRP-1:0] set_stb_o,
    output logic [NUM_GRP-1:0] clr_stb_o,
    output logic [NUM_GRP-1:0] rd_req_o,
    output logic [NUM_GRP-1:0] rd_stat_o
);

    // Returns the byte address of register kind k in group g.
    function automatic logic [ADDR_W-1:0] reg_addr(input int g, input int k);
        return ADDR_W'(GRP_BASE + g * GRP_STRIDE + k * 4);
    endfunction

    always_comb begin
        set_stb_o = '0;
        clr_stb_o = '0;
        rd_req_o  = '0;
        rd_stat_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (sel_i && wr_i && addr_i == reg_addr(g, int'(RK_SET)))
                set_stb_o[g] = 1'b1;
            if (sel_i && wr_i && addr_i == reg_addr(g, int'(RK_CLR)))
                clr_stb_o[g] = 1'b1;
            if (sel_i && !wr_i && addr_i == reg_addr(g, int'(RK_REQ)))
                rd_req_o[g] = 1'b1;
            if (sel_i && !wr_i && addr_i == reg_addr(g, int'(RK_STAT)))
                rd_stat_o[g] = 1'b1;
        end
    end

endmodule

// File: rtl/cg_group.sv
module cg_group
    import clkgate_pkg::*;
#(
    parameter logic [31:0] RST_VAL = '0
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  grp_word_t set_i,
    input  grp_word_t clr_i,
    output grp_word_t req_o,
    output grp_word_t stat_o
);

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // The clear mask wins over the set mask on a shared bit.
        st_d.req  = (st_q.req | set_i) & ~clr_i;
        // Two-stage synchronisation of the request into the status.
        st_d.mid  = st_q.req;
        st_d.stat = st_q.mid;
        // Cycles since reset, saturating at the sync latency.
        if (st_q.age != 2'(SYNC_LAT))
            st_d.age = st_q.age + 2'd1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.req  <= RST_VAL;
            st_q.mid  <= RST_VAL;
            st_q.stat <= RST_VAL;
            st_q.age  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.req;
    assign stat_o = st_q.stat;

    // Bits written as 1 to the set register are on afterwards (no clear on them).
    p_set_bits_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (|set_i) |=> ((req_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

    // Bits written as 1 to the clear register are off afterwards.
    p_clr_bits_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (|clr_i) |=> ((req_o & $past(clr_i)) == '0));

    // Untouched bits keep their value.
    p_untouched_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((req_o ^ $past(req_o)) & ~$past(set_i | clr_i)) == '0));

    // Status lags the request by exactly two cycles.
    p_status_lag_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.age == 2'(SYNC_LAT)) |-> (stat_o == $past(req_o, 2)));

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
    import clkgate_pkg::*;
#(
    parameter int                         NUM_GRP = 2,
    parameter int                         ADDR_W  = 8,
    parameter logic [NUM_GRP*GRP_W-1:0]   RST_REQ = {{(NUM_GRP*GRP_W-1){1'b0}}, 1'b1}
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       bus_sel_i,
    input  logic                       bus_wr_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic [GRP_W-1:0]           bus_wdata_i,
    output logic [GRP_W-1:0]           bus_rdata_o,
    input  logic                       clk_en_i,
    output logic [NUM_GRP*GRP_W-1:0]   gate_o
);

    localparam int NUM_CLK = NUM_GRP * GRP_W;

    logic [NUM_GRP-1:0] set_stb, clr_stb, rd_req, rd_stat;
    grp_word_t          req_w  [NUM_GRP];
    grp_word_t          stat_w [NUM_GRP];
    logic [NUM_CLK-1:0] stat_all;

    cg_decode #(
        .NUM_GRP (NUM_GRP),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .set_stb_o (set_stb),
        .clr_stb_o (clr_stb),
        .rd_req_o  (rd_req),
        .rd_stat_o (rd_stat)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        grp_word_t set_m, clr_m;
        assign set_m = set_stb[g] ? bus_wdata_i : '0;
        assign clr_m = clr_stb[g] ? bus_wdata_i : '0;

        cg_group #(
            .RST_VAL (RST_REQ[g*GRP_W +: GRP_W])
        ) u_grp (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .set_i  (set_m),
            .clr_i  (clr_m),
            .req_o  (req_w[g]),
            .stat_o (stat_w[g])
        );

        assign stat_all[g*GRP_W +: GRP_W] = stat_w[g];

        // A write that misses this group's set and clear registers leaves its request alone.
        p_grp_isolated_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            (bus_sel_i && bus_wr_i
             && bus_addr_i != ADDR_W'(GRP_BASE + g * GRP_STRIDE)
             && bus_addr_i != ADDR_W'(GRP_BASE + g * GRP_STRIDE + 4))
            |=> $stable(req_w[g]));
    end

    // Read mux: only request and status registers return data.
    always_comb begin
        bus_rdata_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_req[g])  bus_rdata_o = bus_rdata_o | req_w[g];
            if (rd_stat[g]) bus_rdata_o = bus_rdata_o | stat_w[g];
        end
    end

    assign gate_o = stat_all & {NUM_CLK{clk_en_i}};

    // Reads that are not of a request or status register return zero.
    p_rd_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && !bus_wr_i && !(|rd_req) && !(|rd_stat)) |-> (bus_rdata_o == '0));

    // With the qualifier low no gate is open.
    p_gate_qual_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_en_i |-> (gate_o == '0));

endmodule

// File: tb/sim_clkgate_bank.sv
module sim_clkgate_bank;

    localparam logic [63:0] RSTV = 64'h8000_0000_0000_0005;
    localparam int NV = 10;

    // Stimulus table: write address, write data, expected request words after it.
    localparam logic [7:0]  V_ADDR [NV] = '{8'h24, 8'h28, 8'h34, 8'h38, 8'h24,
                                            8'h28, 8'h34, 8'h2C, 8'h50, 8'h24};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_00F0, 32'h0000_0011, 32'h0001_0001,
                                            32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF, 32'h0000_1234, 32'hFFFF_FFFF,
                                            32'hA5A5_A5A5};
    localparam logic [31:0] V_EXP0 [NV] = '{32'h0000_00F5, 32'h0000_00E4, 32'h0000_00E4,
                                            32'h0000_00E4, 32'h0000_00E4, 32'h0000_0000,
                                            32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
                                            32'hA5A5_A5A5};
    localparam logic [31:0] V_EXP1 [NV] = '{32'h8000_0000, 32'h8000_0000, 32'h8001_0001,
                                            32'h0001_0001, 32'h0001_0001, 32'h0001_0001,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cen = 1'b1;
    logic [63:0] gate;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    clkgate_bank #(
        .NUM_GRP (2),
        .ADDR_W  (8),
        .RST_REQ (RSTV)
    ) u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .clk_en_i    (cen),
        .gate_o      (gate)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #0.5;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        wait_cyc(5);
        // R6: values during reset
        bus_read(8'h2C, r); check("R6 req0 in reset", 64'(r), 64'(RSTV[31:0]));
        @(negedge clk);
        rst = 1'b0;
        // R6: values right after reset
        bus_read(8'h2C, r); check("R6 req0", 64'(r), 64'(RSTV[31:0]));
        bus_read(8'h3C, r); check("R6 req1", 64'(r), 64'(RSTV[63:32]));
        bus_read(8'h30, r); check("R6 stat0", 64'(r), 64'(RSTV[31:0]));
        bus_read(8'h40, r); check("R6 stat1", 64'(r), 64'(RSTV[63:32]));
        check("R6/R9 gate after reset", gate, RSTV);

        // Vector walk: R1, R2, R3, R4, R8, then status and gates settle (R5, R9)
        for (int v = 0; v < NV; v++) begin
            bus_write(V_ADDR[v], V_DATA[v]);
            bus_read(8'h2C, r); check("R1/R2/R4/R8 vec req0", 64'(r), 64'(V_EXP0[v]));
            bus_read(8'h3C, r); check("R1/R2/R3/R8 vec req1", 64'(r), 64'(V_EXP1[v]));
            wait_cyc(2);
            check("R3/R5/R9 vec gate", gate, {V_EXP1[v], V_EXP0[v]});
        end

        // R5: exact two-cycle lag of status after a clear of bit 0 in group 0
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 8'h28; wdata = 32'h0000_0001;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        bus_read(8'h2C, r); check("R4 req0 one cycle after write", 64'(r), 64'h0000_0000_A5A5_A5A4);
        bus_read(8'h30, r); check("R5 stat0 after E", 64'(r), 64'h0000_0000_A5A5_A5A5);
        @(negedge clk);
        bus_read(8'h30, r); check("R5 stat0 after E+1", 64'(r), 64'h0000_0000_A5A5_A5A5);
        check("R5 gate0 after E+1", 64'(gate[0]), 64'd1);
        @(negedge clk);
        bus_read(8'h30, r); check("R5 stat0 after E+2", 64'(r), 64'h0000_0000_A5A5_A5A4);
        check("R5 gate0 after E+2", 64'(gate[0]), 64'd0);

        // R3: clock 32 is group 1 bit 0 and gate_o[32]
        bus_write(8'h38, 32'h0000_0001);
        wait_cyc(2);
        check("R3 gate32 off", 64'(gate[32]), 64'd0);
        check("R3 group0 untouched", 64'(gate[31:0]), 64'h0000_0000_A5A5_A5A4);
        bus_read(8'h40, r); check("R3 stat1", 64'(r), 64'h0000_0000_FFFF_FFFE);

        // R7: set and clear registers read as zero
        bus_read(8'h24, r); check("R7 read set0", 64'(r), 64'd0);
        bus_read(8'h28, r); check("R7 read clr0", 64'(r), 64'd0);
        bus_read(8'h34, r); check("R7 read set1", 64'(r), 64'd0);
        bus_read(8'h38, r); check("R7 read clr1", 64'(r), 64'd0);

        // R8: unmapped and misaligned reads, and a status-register write
        bus_read(8'h20, r); check("R8 read 0x20", 64'(r), 64'd0);
        bus_read(8'h2E, r); check("R8 read misaligned", 64'(r), 64'd0);
        bus_read(8'h44, r); check("R8 read 0x44", 64'(r), 64'd0);
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'h25, 32'hFFFF_FFFF);
        bus_read(8'h2C, r); check("R8 writes ignored req0", 64'(r), 64'h0000_0000_A5A5_A5A4);

        // R9: qualifier low closes every gate, high reopens
        cen = 1'b0;
        #0.5;
        check("R9 gate with qualifier low", gate, 64'd0);
        cen = 1'b1;
        #0.5;
        check("R9 gate with qualifier high", gate, 64'hFFFF_FFFE_A5A5_A5A4);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule